// File: doc/BRIEF.md
# Spread-Spectrum Receive Header Checker

This block sits behind the despreader and descrambler of a direct-sequence receiver. It starts work once the acquisition logic reports initial PN lock. It then hunts the incoming bit stream for a programmed 16-bit start-of-frame word, and a hunt timer limits how long it looks. A packet is only declared once that exact word has been seen; PN lock on its own never opens a packet.

After the start word, the block collects the header fields that the selected link mode carries. It checks a CRC-16 computed locally over the start word and those fields, and then forwards the payload bits inside a data-ready envelope. Either the received length field or an external end-of-carrier strobe closes the envelope. A CRC failure either drops the link or is tolerated, depending on a configuration bit. In the mode that allows a modulation change, the signal field decides whether the demodulator is asked to switch to DQPSK for the payload.

The block feeds a downstream processor. Any drop or end of packet returns it to idle, where it waits for the next PN lock pulse.

Top module: `rxhdr_chk`

## Requirements
- R1: While reset is asserted and on the first cycle after it, link_drop, data_rdy, pay_vld, pay_bit, qpsk_sel and all captured field outputs are zero.
- R2: A header is started only when the last 16 received bits equal cfg_sfd exactly, the most recent bit being bit 0. A word that differs in any bit opens no envelope.
- R3: The hunt timer starts from zero on the rising edge that samples pn_sync in idle. If no start word is found, link_drop is high for exactly the one cycle that begins cfg_timeout+1 rising edges after that edge.
- R4: Header layout after the start word, with every field sent MSB first. Mode 0 has no fields. Mode 1 has a 16-bit CRC only. Modes 2 and 3 have signal (8), service (8), length (16) and then CRC (16). The captured values appear on hdr_signal, hdr_service, hdr_length and hdr_crc from the cycle after the last header bit.
- R5: The check value is the complement of a CRC-16 with polynomial x^16+x^12+x^5+1 and an all-ones preset. It runs MSB first over the start word followed by every field that precedes the CRC. A received CRC equal to it is accepted.
- R6: With cfg_crc_drop=1, a CRC mismatch gives a one-cycle link_drop pulse in the cycle after the last CRC bit, and no payload is forwarded.
- R7: With cfg_crc_drop=0, a CRC mismatch raises no link_drop and payload forwarding proceeds normally.
- R8: In mode 3, a signal field equal to 8'h14 sets qpsk_sel from header end through the payload. Any other value, or any other mode, keeps qpsk_sel low.
- R9: With cfg_len_en=1 in modes 2 and 3, exactly hdr_length payload bits are forwarded, and data_rdy is low in the cycle after the last one. A length of zero forwards nothing. Later bits are ignored.
- R10: A cycle with carrier_end high during the payload ends the envelope; data_rdy is low in the next cycle and the bit offered with it is discarded.
- R11: Payload bits appear in order on pay_bit with pay_vld, one cycle after they are offered. pay_vld is only high inside data_rdy, data_rdy rises together with the first pay_vld, and data_rdy stays high across gaps in bit_vld.
- R12: In idle, bits and carrier_end have no effect and nothing is forwarded until a pn_sync pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pn_sync | input | 1 | Pulse: initial PN lock reported |
| bit_vld | input | 1 | Strobe for bit_in |
| bit_in | input | 1 | Descrambled received bit |
| carrier_end | input | 1 | End-of-carrier indication |
| cfg_mode | input | 2 | Link mode 0..3 |
| cfg_sfd | input | 16 | Expected start-of-frame word |
| cfg_timeout | input | TMR_W | Hunt limit in cycles |
| cfg_len_en | input | 1 | Close envelope from length field |
| cfg_crc_drop | input | 1 | Drop link on CRC mismatch |
| link_drop | output | 1 | One-cycle drop pulse |
| hdr_signal | output | 8 | Captured signal field |
| hdr_service | output | 8 | Captured service field |
| hdr_length | output | 16 | Captured length field |
| hdr_crc | output | 16 | Captured CRC field |
| qpsk_sel | output | 1 | Request DQPSK payload demodulation |
| data_rdy | output | 1 | Payload envelope |
| pay_vld | output | 1 | Payload bit strobe |
| pay_bit | output | 1 | Payload bit |

## Verification
Packets are sent in every mode behind a run of preamble ones. They carry both correct and corrupted CRCs under both drop policies, so a drop can be told apart from a tolerated error and from a clean pass. Payloads are offered with regular gaps and are closed by the length field (shorter, exactly equal and zero) or by carrier_end, which separates the two termination paths and the envelope width. A near-miss start word, a bare timeout and bits offered in idle show that nothing but an exact match after PN lock opens a packet. The signal field is varied in modes 2 and 3 to isolate the modulation request.

// File: rtl/rxhdr_pkg.sv
package rxhdr_pkg;

    localparam int SFD_W   = 16;
    localparam int FCS_W   = 16;
    localparam int LEN_W   = 16;
    localparam int HDR_MAX = 48;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_HDR,
        ST_PAY
    } st_e;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

    function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] acc;
        acc = c;
        for (int i = 15; i >= 0; i--) begin
            acc = crc_step(acc, w[i]);
        end
        return acc;
    endfunction

    // header bits after the start word, per link mode
    function automatic logic [15:0] hdr_bits(input logic [1:0] mode);
        case (mode)
            2'd0:    return 16'd0;
            2'd1:    return 16'd16;
            default: return 16'd48;
        endcase
    endfunction

endpackage

// File: rtl/rxhdr_sfd.sv
module rxhdr_sfd #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic [W-1:0] pattern,
    output logic         hit
);
    localparam int FW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [FW-1:0] fill;
    } sfd_t;

    sfd_t s_d, s_q;
    logic [W-1:0] win;
    logic         full;

    always_comb begin
        win  = {s_q.sr[W-2:0], bit_in};
        full = (s_q.fill >= FW'(W - 1));
        hit  = shift_en && full && (win == pattern);
        s_d  = s_q;
        if (clr) begin
            s_d = '0;
        end else if (shift_en) begin
            s_d.sr = win;
            if (s_q.fill != FW'(W)) s_d.fill = s_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    sfd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hit);

endmodule

// File: rtl/rxhdr_crc.sv
module rxhdr_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld,
    input  logic [15:0] seed_word,
    input  logic        en,
    input  logic        bit_in,
    output logic [15:0] crc_q
);
    import rxhdr_pkg::*;

    logic [15:0] crc_d;

    always_comb begin
        crc_d = crc_q;
        if (ld)      crc_d = crc_word(CRC_INIT, seed_word);
        else if (en) crc_d = crc_step(crc_q, bit_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_INIT;
        else        crc_q <= crc_d;
    end

    // R5
    crc_ld_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> !en);

    // R5
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !en) |=> $stable(crc_q));

endmodule

// File: rtl/rxhdr_chk.sv
module rxhdr_chk #(
    parameter int          TMR_W    = 16,
    parameter logic [7:0]  QPSK_SIG = 8'h14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pn_sync,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             carrier_end,
    input  logic [1:0]       cfg_mode,
    input  logic [15:0]      cfg_sfd,
    input  logic [TMR_W-1:0] cfg_timeout,
    input  logic             cfg_len_en,
    input  logic             cfg_crc_drop,
    output logic             link_drop,
    output logic [7:0]       hdr_signal,
    output logic [7:0]       hdr_service,
    output logic [15:0]      hdr_length,
    output logic [15:0]      hdr_crc,
    output logic             qpsk_sel,
    output logic             data_rdy,
    output logic             pay_vld,
    output logic             pay_bit
);
    import rxhdr_pkg::*;

    typedef struct packed {
        st_e                state;
        logic [TMR_W-1:0]   tmr;
        logic [LEN_W-1:0]   cnt;
        logic [HDR_MAX-1:0] sr;
        logic [7:0]         sig;
        logic [7:0]         svc;
        logic [LEN_W-1:0]   len;
        logic [FCS_W-1:0]   fcs;
        logic               qpsk;
        logic               drop;
        logic               rdy;
        logic               pvld;
        logic               pbit;
    } ctl_t;

    ctl_t r_d, r_q;

    logic               hunt_clr, hunt_en, sfd_hit;
    logic               crc_ld, crc_en;
    logic [15:0]        crc_q;
    logic [HDR_MAX-1:0] nsr;
    logic [15:0]        rx_fcs;
    logic [15:0]        hb;
    logic               len_use;

    rxhdr_sfd #(.W(SFD_W)) u_sfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hunt_clr),
        .shift_en (hunt_en),
        .bit_in   (bit_in),
        .pattern  (cfg_sfd),
        .hit      (sfd_hit)
    );

    rxhdr_crc u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (crc_ld),
        .seed_word (cfg_sfd),
        .en        (crc_en),
        .bit_in    (bit_in),
        .crc_q     (crc_q)
    );

    always_comb begin
        r_d      = r_q;
        r_d.drop = 1'b0;
        r_d.pvld = 1'b0;
        r_d.pbit = 1'b0;
        hunt_clr = 1'b0;
        hunt_en  = 1'b0;
        crc_ld   = 1'b0;
        crc_en   = 1'b0;
        nsr      = {r_q.sr[HDR_MAX-2:0], bit_in};
        rx_fcs   = nsr[15:0];
        hb       = hdr_bits(cfg_mode);
        len_use  = cfg_len_en && cfg_mode[1];

        case (r_q.state)
            ST_IDLE: begin
                r_d.rdy  = 1'b0;
                r_d.qpsk = 1'b0;
                if (pn_sync) begin
                    r_d.state = ST_HUNT;
                    r_d.tmr   = '0;
                    hunt_clr  = 1'b1;
                end
            end
            ST_HUNT: begin
                hunt_en = bit_vld;
                if (sfd_hit) begin
                    crc_ld    = 1'b1;
                    r_d.cnt   = '0;
                    r_d.sr    = '0;
                    r_d.state = (hb == 16'd0) ? ST_PAY : ST_HDR;
                end else if (r_q.tmr >= cfg_timeout) begin
                    r_d.drop  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_HDR: begin
                if (bit_vld) begin
                    r_d.sr  = nsr;
                    r_d.cnt = r_q.cnt + 1'b1;
                    crc_en  = (r_q.cnt < hb - 16'd16);
                    if (r_q.cnt == hb - 16'd1) begin
                        r_d.cnt = '0;
                        r_d.fcs = rx_fcs;
                        if (cfg_mode[1]) begin
                            r_d.sig = nsr[47:40];
                            r_d.svc = nsr[39:32];
                            r_d.len = nsr[31:16];
                        end
                        if ((rx_fcs != ~crc_q) && cfg_crc_drop) begin
                            r_d.drop  = 1'b1;
                            r_d.state = ST_IDLE;
                        end else if (len_use && (nsr[31:16] == 16'd0)) begin
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.state = ST_PAY;
                            r_d.qpsk  = (cfg_mode == 2'd3) && (nsr[47:40] == QPSK_SIG);
                        end
                    end
                end
            end
            ST_PAY: begin
                if (carrier_end) begin
                    r_d.state = ST_IDLE;
                    r_d.rdy   = 1'b0;
                end else if (bit_vld) begin
                    r_d.pvld = 1'b1;
                    r_d.pbit = bit_in;
                    r_d.rdy  = 1'b1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (len_use && (r_q.cnt == r_q.len - 16'd1)) r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign link_drop   = r_q.drop;
    assign hdr_signal  = r_q.sig;
    assign hdr_service = r_q.svc;
    assign hdr_length  = r_q.len;
    assign hdr_crc     = r_q.fcs;
    assign qpsk_sel    = r_q.qpsk;
    assign data_rdy    = r_q.rdy;
    assign pay_vld     = r_q.pvld;
    assign pay_bit     = r_q.pbit;

    // R11
    pay_in_env_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld |-> data_rdy);

    // R11
    env_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy) |-> pay_vld);

    // R3
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_drop |=> !link_drop);

    // R8
    qpsk_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qpsk_sel |-> (r_q.state == ST_PAY || $past(r_q.state == ST_PAY)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && $past(r_q.state == ST_IDLE)) |-> (!data_rdy && !pay_vld));

    // R2
    hunt_no_env_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HUNT) |-> !data_rdy);

endmodule

// File: tb/sim_rxhdr_chk.sv
`timescale 1ns/1ps
module sim_rxhdr_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pn_sync = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, carrier_end = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [15:0] cfg_sfd = 16'h05CF;
    logic [15:0] cfg_timeout = 16'd200;
    logic        cfg_len_en = 1'b0, cfg_crc_drop = 1'b0;
    logic        link_drop, qpsk_sel, data_rdy, pay_vld, pay_bit;
    logic [7:0]  hdr_signal, hdr_service;
    logic [15:0] hdr_length, hdr_crc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit exp_q[$];

    always #2.5 clk = ~clk;

    rxhdr_chk #(.TMR_W(16), .QPSK_SIG(8'h14)) u0 (
        .clk(clk), .rst_n(rst_n), .pn_sync(pn_sync), .bit_vld(bit_vld), .bit_in(bit_in),
        .carrier_end(carrier_end), .cfg_mode(cfg_mode), .cfg_sfd(cfg_sfd),
        .cfg_timeout(cfg_timeout), .cfg_len_en(cfg_len_en), .cfg_crc_drop(cfg_crc_drop),
        .link_drop(link_drop), .hdr_signal(hdr_signal), .hdr_service(hdr_service),
        .hdr_length(hdr_length), .hdr_crc(hdr_crc), .qpsk_sel(qpsk_sel),
        .data_rdy(data_rdy), .pay_vld(pay_vld), .pay_bit(pay_bit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] tb_fcs(input logic [47:0] v, input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = n - 1; i >= 0; i--) begin
            logic top;
            top = c[15];
            c   = c << 1;
            if (top ^ v[i]) c = c ^ 16'h1021;
        end
        return ~c;
    endfunction

    // monitor: pops the scoreboard as payload bits emerge
    always @(negedge clk) begin
        if (rst_n && !done && pay_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected payload bit", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(pay_bit == e, "R11 payload bit order", pay_bit, e);
            end
        end
    end

    task automatic send_bit(input logic b);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic sync_pulse();
        pn_sync = 1'b1;
        @(negedge clk);
        pn_sync = 1'b0;
    endtask

    function automatic bit pbit_of(input int i, input logic [7:0] s);
        return ((i * 29 + int'(s)) % 7) < 3;
    endfunction

    task automatic run_pkt(input logic [1:0] m, input logic [7:0] sg, input logic [7:0] sv,
                           input logic [15:0] ln, input int npay, input bit bad,
                           input bit lenen, input bit dropen, input bit exp_qpsk);
        logic [15:0] fcs;
        bit          goes, use_len;
        int          nexp;
        cfg_mode     = m;
        cfg_len_en   = lenen;
        cfg_crc_drop = dropen;
        if (m == 2'd1) fcs = tb_fcs({32'h0, cfg_sfd}, 16);
        else           fcs = tb_fcs({cfg_sfd, sg, sv, ln}, 48);
        if (bad) fcs = fcs ^ 16'h0001;
        goes    = !(bad && dropen && m != 2'd0);
        use_len = lenen && m[1];
        nexp    = npay;
        if (use_len && int'(ln) < nexp) nexp = int'(ln);
        if (goes) for (int i = 0; i < nexp; i++) exp_q.push_back(pbit_of(i, sg));

        sync_pulse();
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        for (int i = 15; i >= 0; i--) send_bit(cfg_sfd[i]);
        if (m[1]) begin
            for (int i = 7; i >= 0; i--)  send_bit(sg[i]);
            for (int i = 7; i >= 0; i--)  send_bit(sv[i]);
            for (int i = 15; i >= 0; i--) send_bit(ln[i]);
        end
        if (m != 2'd0) begin
            for (int i = 15; i >= 0; i--) send_bit(fcs[i]);
            if (bad && dropen) chk(link_drop == 1'b1, "R6 drop on crc error", link_drop, 1);
            else if (bad)      chk(link_drop == 1'b0, "R7 crc error tolerated", link_drop, 0);
            else               chk(link_drop == 1'b0, "R5 good crc accepted", link_drop, 0);
            if (goes) chk(hdr_crc == fcs, "R5 captured crc", hdr_crc, fcs);
        end
        if (m[1] && goes) begin
            chk(hdr_signal == sg,  "R4 signal field",  hdr_signal, sg);
            chk(hdr_service == sv, "R4 service field", hdr_service, sv);
            chk(hdr_length == ln,  "R4 length field",  hdr_length, ln);
        end

        for (int i = 0; i < npay; i++) begin
            send_bit(pbit_of(i, sg));
            if (i == 0 && goes && nexp > 0)
                chk(qpsk_sel == exp_qpsk, "R8 modulation request", qpsk_sel, exp_qpsk);
            if (use_len && nexp > 0 && i == nexp - 1) begin
                @(negedge clk);
                chk(data_rdy == 1'b0, "R9 envelope closes after length bits", data_rdy, 0);
            end
            if (i % 4 == 3) @(negedge clk);
        end
        if (goes && !use_len && nexp > 0)
            chk(data_rdy == 1'b1, "R11 envelope held across gaps", data_rdy, 1);
        carrier_end = 1'b1;
        bit_vld     = 1'b1;
        bit_in      = 1'b1;
        @(negedge clk);
        carrier_end = 1'b0;
        bit_vld     = 1'b0;
        chk(data_rdy == 1'b0, "R10 carrier end closes envelope", data_rdy, 0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 R10 all expected bits seen", exp_q.size(), 0);
        chk(qpsk_sel == 1'b0, "R12 idle after packet", qpsk_sel, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({link_drop, data_rdy, pay_vld, pay_bit, qpsk_sel} == 5'b0, "R1 outputs in reset",
            {link_drop, data_rdy, pay_vld, pay_bit, qpsk_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({hdr_signal, hdr_service, hdr_length, hdr_crc} == 48'h0, "R1 fields after reset",
            hdr_length, 0);
        chk(data_rdy == 1'b0 && link_drop == 1'b0, "R1 envelope after reset", data_rdy, 0);

        // R12: a full start word and payload offered in idle
        cfg_mode = 2'd0;
        for (int i = 15; i >= 0; i--) send_bit(cfg_sfd[i]);
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        chk(data_rdy == 1'b0, "R12 idle ignores bits", data_rdy, 0);

        // R3: timeout with no bits at all
        cfg_timeout = 16'd30;
        pn_sync = 1'b1;
        @(negedge clk);
        pn_sync = 1'b0;
        repeat (30) @(negedge clk);
        chk(link_drop == 1'b0, "R3 no drop before limit", link_drop, 0);
        @(negedge clk);
        chk(link_drop == 1'b1, "R3 drop at limit", link_drop, 1);
        @(negedge clk);
        chk(link_drop == 1'b0, "R3 drop lasts one cycle", link_drop, 0);

        // R2: near-miss start word
        cfg_timeout = 16'd200;
        cfg_mode    = 2'd0;
        sync_pulse();
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        for (int i = 15; i >= 0; i--) send_bit(cfg_sfd[i] ^ (i == 0));
        for (int i = 0; i < 40; i++) send_bit(pbit_of(i, 8'h00));
        chk(data_rdy == 1'b0, "R2 near-miss opens nothing", data_rdy, 0);
        repeat (220) @(negedge clk);

        run_pkt(2'd0, 8'h00, 8'h00, 16'd0,  10, 1'b0, 1'b0, 1'b0, 1'b0);
        run_pkt(2'd1, 8'h00, 8'h00, 16'd0,  9,  1'b0, 1'b0, 1'b1, 1'b0);
        run_pkt(2'd1, 8'h00, 8'h00, 16'd0,  9,  1'b1, 1'b0, 1'b1, 1'b0);
        run_pkt(2'd1, 8'h00, 8'h00, 16'd0,  7,  1'b1, 1'b0, 1'b0, 1'b0);
        run_pkt(2'd2, 8'h14, 8'h5A, 16'd9,  14, 1'b0, 1'b1, 1'b1, 1'b0);
        run_pkt(2'd3, 8'h14, 8'hC3, 16'd40, 12, 1'b0, 1'b0, 1'b1, 1'b1);
        run_pkt(2'd3, 8'h0A, 8'h01, 16'd20, 20, 1'b0, 1'b1, 1'b1, 1'b0);
        run_pkt(2'd2, 8'h33, 8'h77, 16'd0,  6,  1'b0, 1'b1, 1'b1, 1'b0);
        run_pkt(2'd3, 8'h14, 8'h99, 16'd6,  10, 1'b1, 1'b1, 1'b0, 1'b1);
        run_pkt(2'd2, 8'hA5, 8'h3C, 16'd5,  8,  1'b1, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule